// File: doc/BRIEF.md
# Parallel Port Interrupt Register Block

This block gathers interrupt events from the peripheral side of a parallel port controller. Each event sets a sticky bit in a 7-bit pending register, and a second register holds one enable bit per event. The block drives one registered interrupt request to a local processor. That request is high while any pending bit has its enable bit set. Software reaches both registers over a byte-wide bus with an address, a write strobe, a read strobe and data in both directions. Reads take no wait states.

Most events arrive from the port state machine as pulses or levels and are latched as they come, with two exceptions:
- **Host initialise line.** This line is asynchronous and active low. It passes through a two-flop synchronizer and then a two-state line tracker, with states LN_HIGH and LN_LOW. The transition LN_HIGH→LN_LOW emits one fall pulse. The transition LN_LOW→LN_HIGH emits nothing. The fall pulse raises the host-initialise event, but only in compatibility mode.
- **Direction change.** This event is accepted only in the two bidirectional modes.

A write of any value to the pending register clears all of it. An event that arrives in the same cycle as that write still survives.

Top module: `ppirq_regs`

## Requirements
- R1: After reset, the enable register reads 0x00, the pending register reads 0x00 and `irq` is 0.
- R2: Address 0x22 selects the enable register and address 0x23 selects the pending register. `bus_rdata` shows the selected register in the same cycle that `bus_rd` is high. It reads 0x00 when `bus_rd` is low or the address is unmapped. A write to an unmapped address changes neither register.
- R3: Bit 7 of both registers always reads 0, and writing 1 to it has no effect.
- R4: An event that is high at a rising clock edge sets its pending bit at that edge. The bit holds until the next pending-register write, whatever the enable bit is. The bit positions are: 6 timer overflow (`ev_tmr`), 5 negotiation change (`ev_neg`), 4 signal change (`ev_sig`), 3 address written (`ev_adr`), 2 direction change (`ev_dir`), 1 ID request (`ev_idr`), 0 host initialise.
- R5: `irq` equals the OR over bits 0 to 6 of pending AND enable, delayed by one clock. An enable bit gates only the pending bit at its own position.
- R6: A write of any data to 0x23 clears every pending bit, and `irq` falls one clock later.
- R7: An event that is present in the same cycle as a pending-register write is set after that write, not cleared by it.
- R8: A falling edge on `host_init_n`, after synchronization, sets bit 0 only when `port_mode` is 0 (compatibility). A line that stays low does not set the bit again. A rising edge does not set it. An edge in any other mode is ignored.
- R9: `ev_dir` sets bit 2 only when `port_mode` is 2 or 3 (the bidirectional modes). In modes 0 and 1 it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| port_mode | input | 2 | 0 compatibility, 1 reverse nibble/byte, 2 and 3 bidirectional |
| ev_tmr | input | 1 | Timer overflow event |
| ev_neg | input | 1 | Negotiation change event |
| ev_sig | input | 1 | Signal change event |
| ev_adr | input | 1 | Host wrote an address event |
| ev_dir | input | 1 | Direction change event |
| ev_idr | input | 1 | ID request event |
| host_init_n | input | 1 | Raw asynchronous host initialise line, active low |
| irq | output | 1 | Registered interrupt request |

## Verification
Most internal faults show up within a single read of 0x23 made after a stimulus:
- A wrong pending bit shows up in that read. This covers a lost, misplaced or mode-qualified event, and a bit that should have survived a clear.
- A wrong enable bit or a broken gating term shows up on `irq` exactly one cycle after the pending bit changes. The bench samples `irq` both at that cycle and one cycle earlier.

The host initialise path is slower because of its synchronizer and tracker. A tracker stuck in the wrong state shows up as a missing bit 0, or an extra one, three clocks after the line moves.

// File: rtl/ppirq_pkg.sv
package ppirq_pkg;

    localparam int unsigned REG_W   = 8;
    localparam int unsigned EV_CNT  = 7;

    localparam logic [7:0] ADDR_ENABLE  = 8'h22;
    localparam logic [7:0] ADDR_PENDING = 8'h23;

    localparam int unsigned BIT_INIT = 0;
    localparam int unsigned BIT_IDR  = 1;
    localparam int unsigned BIT_DIR  = 2;
    localparam int unsigned BIT_ADR  = 3;
    localparam int unsigned BIT_SIG  = 4;
    localparam int unsigned BIT_NEG  = 5;
    localparam int unsigned BIT_TMR  = 6;

    typedef enum logic [1:0] {
        MODE_COMPAT  = 2'd0,
        MODE_REVERSE = 2'd1,
        MODE_ECP     = 2'd2,
        MODE_EPP     = 2'd3
    } port_mode_e;

    typedef enum logic {
        LN_HIGH = 1'b0,
        LN_LOW  = 1'b1
    } line_st_e;

endpackage

// File: rtl/ppirq_sync.sv
module ppirq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    // Resets to the idle-high level of an active-low line.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/ppirq_edge_fsm.sv
module ppirq_edge_fsm
    import ppirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_s,
    output logic fall
);
    line_st_e state_q;
    line_st_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LN_HIGH;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        fall    = 1'b0;
        unique case (state_q)
            LN_HIGH: begin
                if (!line_s) begin
                    state_d = LN_LOW;
                    fall    = 1'b1;
                end
            end
            LN_LOW: begin
                if (line_s) state_d = LN_HIGH;
            end
        endcase
    end
endmodule

// File: rtl/ppirq_evt_qual.sv
module ppirq_evt_qual
    import ppirq_pkg::*;
#(
    parameter int unsigned EVN = EV_CNT
) (
    input  logic [1:0]     port_mode,
    input  logic           ev_tmr,
    input  logic           ev_neg,
    input  logic           ev_sig,
    input  logic           ev_adr,
    input  logic           ev_dir,
    input  logic           ev_idr,
    input  logic           init_fall,
    output logic [EVN-1:0] set_vec
);
    logic bidir;
    logic compat;

    assign bidir  = (port_mode == MODE_ECP) || (port_mode == MODE_EPP);
    assign compat = (port_mode == MODE_COMPAT);

    always_comb begin
        set_vec           = '0;
        set_vec[BIT_TMR]  = ev_tmr;
        set_vec[BIT_NEG]  = ev_neg;
        set_vec[BIT_SIG]  = ev_sig;
        set_vec[BIT_ADR]  = ev_adr;
        set_vec[BIT_DIR]  = ev_dir & bidir;
        set_vec[BIT_IDR]  = ev_idr;
        set_vec[BIT_INIT] = init_fall & compat;
    end
endmodule

// File: rtl/ppirq_pending.sv
module ppirq_pending #(
    parameter int unsigned EVN = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic [EVN-1:0] set_vec,
    output logic [EVN-1:0] pend
);
    for (genvar i = 0; i < EVN; i++) begin : g_bit
        // A set in the same cycle as a clear wins over the clear.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          pend[i] <= 1'b0;
            else if (set_vec[i]) pend[i] <= 1'b1;
            else if (clr)        pend[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/ppirq_regs.sv
module ppirq_regs
    import ppirq_pkg::*;
#(
    parameter int unsigned AW          = 8,
    parameter int unsigned DW          = REG_W,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [1:0]    port_mode,
    input  logic          ev_tmr,
    input  logic          ev_neg,
    input  logic          ev_sig,
    input  logic          ev_adr,
    input  logic          ev_dir,
    input  logic          ev_idr,
    input  logic          host_init_n,
    output logic          irq
);
    localparam int unsigned EVN = DW - 1;

    logic           sel_en;
    logic           sel_pd;
    logic           clr;
    logic           init_s;
    logic           init_fall;
    logic [EVN-1:0] set_vec;
    logic [EVN-1:0] pend;
    logic [EVN-1:0] enable;

    assign sel_en = (bus_addr == AW'(ADDR_ENABLE));
    assign sel_pd = (bus_addr == AW'(ADDR_PENDING));
    assign clr    = bus_wr & sel_pd;

    ppirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (host_init_n),
        .dout (init_s)
    );

    ppirq_edge_fsm u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .line_s(init_s),
        .fall  (init_fall)
    );

    ppirq_evt_qual #(.EVN(EVN)) u_qual (
        .port_mode(port_mode),
        .ev_tmr   (ev_tmr),
        .ev_neg   (ev_neg),
        .ev_sig   (ev_sig),
        .ev_adr   (ev_adr),
        .ev_dir   (ev_dir),
        .ev_idr   (ev_idr),
        .init_fall(init_fall),
        .set_vec  (set_vec)
    );

    ppirq_pending #(.EVN(EVN)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .set_vec(set_vec),
        .pend   (pend)
    );

    logic unused_msb;
    assign unused_msb = bus_wdata[DW-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               enable <= '0;
        else if (bus_wr & sel_en) enable <= bus_wdata[EVN-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(pend & enable);
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (sel_en)      bus_rdata = {1'b0, enable};
            else if (sel_pd) bus_rdata = {1'b0, pend};
        end
    end
endmodule

// File: rtl/ppirq_regs_chk.sv
module ppirq_regs_chk #(
    parameter int unsigned EVN = 7
) (
    input logic           clk,
    input logic           rst_n,
    input logic [7:0]     bus_rdata,
    input logic [1:0]     port_mode,
    input logic           irq,
    input logic           clr,
    input logic [EVN-1:0] set_vec,
    input logic [EVN-1:0] pend,
    input logic [EVN-1:0] enable
);
    assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[7] == 1'b0);

    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((pend & $past(pend)) == $past(pend)));

    assert_irq_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & enable) == '0) |=> !irq);

    assert_irq_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & enable) != '0) |=> irq);

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && set_vec == '0) |=> (pend == '0));

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((pend & $past(set_vec)) == $past(set_vec)));

    assert_init_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend[0]) |-> ($past(port_mode) == 2'd0));

    assert_dir_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend[2]) |-> ($past(port_mode) >= 2'd2));
endmodule

bind ppirq_regs ppirq_regs_chk #(.EVN(EVN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_rdata(bus_rdata),
    .port_mode(port_mode),
    .irq      (irq),
    .clr      (clr),
    .set_vec  (set_vec),
    .pend     (pend),
    .enable   (enable)
);

// File: tb/ppirq_regs_tb.sv
`timescale 1ns/1ps
module ppirq_regs_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] port_mode = 2'd0;
    logic       ev_tmr = 0, ev_neg = 0, ev_sig = 0, ev_adr = 0, ev_dir = 0, ev_idr = 0;
    logic       host_init_n = 1'b1;
    logic       irq;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    event       rd_sample;

    always #2.5 clk = ~clk;

    ppirq_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .port_mode(port_mode), .ev_tmr(ev_tmr), .ev_neg(ev_neg),
        .ev_sig(ev_sig), .ev_adr(ev_adr), .ev_dir(ev_dir), .ev_idr(ev_idr),
        .host_init_n(host_init_n), .irq(irq)
    );

    // Monitor: pops the expected read value when a read is sampled.
    initial begin
        forever begin
            @(rd_sample);
            begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                total++;
                if (bus_rdata !== e) begin
                    bad++;
                    $display("FAIL %s: rdata=%h expected=%h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic check_bit(input logic act, input logic exp, input string t);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", t, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        #1;
        ->rd_sample;
        #0.5;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic pulse(input int b);
        @(negedge clk);
        case (b)
            6: ev_tmr = 1; 5: ev_neg = 1; 4: ev_sig = 1;
            3: ev_adr = 1; 2: ev_dir = 1; default: ev_idr = 1;
        endcase
        @(negedge clk);
        {ev_tmr, ev_neg, ev_sig, ev_adr, ev_dir, ev_idr} = '0;
    endtask

    initial begin
        #1_000_000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        check_bit(irq, 1'b0, "R1 irq after reset");
        rd(8'h22, 8'h00, "R1 enable reset");
        rd(8'h23, 8'h00, "R1 pending reset");

        // R2 / R3 enable access, reserved bit
        wr(8'h22, 8'hFF);
        rd(8'h22, 8'h7F, "R3 enable bit7 reads 0");
        wr(8'h22, 8'h00);
        rd(8'h22, 8'h00, "R2 enable written back");

        // R4 sticky latch with enables off
        pulse(5);
        cyc(2);
        rd(8'h23, 8'h20, "R4 negotiation bit 5");
        pulse(6); pulse(4); pulse(3); pulse(1);
        cyc(2);
        rd(8'h23, 8'h7A, "R4 several events");
        check_bit(irq, 1'b0, "R5 irq masked");

        // R5 gating per bit
        wr(8'h22, 8'h01);
        cyc(2);
        check_bit(irq, 1'b0, "R5 enable of clear bit");
        wr(8'h22, 8'h10);
        cyc(1);
        check_bit(irq, 1'b1, "R5 enable of pending bit");

        // R6 clear by any data
        wr(8'h23, 8'h55);
        rd(8'h23, 8'h00, "R6 pending cleared");
        check_bit(irq, 1'b0, "R6 irq removed");

        // R5 one-cycle latency: sig high at edge k, irq after k+1
        @(negedge clk);
        ev_sig = 1;
        @(negedge clk);
        ev_sig = 0;
        check_bit(irq, 1'b0, "R5 irq not yet");
        @(negedge clk);
        check_bit(irq, 1'b1, "R5 irq one cycle later");

        // R7 event wins over simultaneous clear
        wr(8'h23, 8'h00);
        @(negedge clk);
        bus_addr = 8'h23; bus_wdata = 8'hFF; bus_wr = 1; ev_neg = 1;
        @(negedge clk);
        bus_wr = 0; ev_neg = 0;
        rd(8'h23, 8'h20, "R7 event kept over clear");

        // R9 direction qualification
        wr(8'h23, 8'h00);
        port_mode = 2'd3;
        pulse(2);
        rd(8'h23, 8'h04, "R9 dir in EPP");
        wr(8'h23, 8'h00);
        port_mode = 2'd0;
        pulse(2);
        rd(8'h23, 8'h00, "R9 dir ignored compat");
        port_mode = 2'd1;
        pulse(2);
        rd(8'h23, 8'h00, "R9 dir ignored reverse");
        port_mode = 2'd2;
        pulse(2);
        rd(8'h23, 8'h04, "R9 dir in ECP");

        // R8 host initialise edge
        wr(8'h22, 8'h00);
        wr(8'h23, 8'h00);
        port_mode = 2'd0;
        @(negedge clk);
        host_init_n = 0;
        cyc(5);
        rd(8'h23, 8'h01, "R8 fall in compat");
        wr(8'h23, 8'h00);
        cyc(4);
        rd(8'h23, 8'h00, "R8 held low no retrigger");
        host_init_n = 1;
        cyc(5);
        rd(8'h23, 8'h00, "R8 rise ignored");
        port_mode = 2'd3;
        host_init_n = 0;
        cyc(5);
        rd(8'h23, 8'h00, "R8 fall ignored in EPP");
        host_init_n = 1;
        cyc(4);
        port_mode = 2'd0;
        host_init_n = 0;
        cyc(5);
        rd(8'h23, 8'h01, "R8 second fall compat");

        // R2 unmapped and strobe-off
        wr(8'h22, 8'h3C);
        wr(8'h24, 8'hFF);
        rd(8'h22, 8'h3C, "R2 unmapped write no effect");
        rd(8'h20, 8'h00, "R2 unmapped read zero");
        @(negedge clk);
        bus_addr = 8'h22;
        bus_rd = 0;
        #1;
        total++;
        if (bus_rdata !== 8'h00) begin
            bad++;
            $display("FAIL R2 no strobe: actual=%h expected=00", bus_rdata);
        end

        cyc(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule